// File: doc/BRIEF.md
# Dual-Channel Interrupt and General-Purpose Port Registers

This block holds the chip-level registers shared by the two serial channels of a serial controller. Each channel reports a transmit-ready flag and a receive-ready flag. The block packs these flags into an interrupt status word, with four bit positions for each channel. A mask register, written at the same offset where the status word is read, selects which flags drive the active-low interrupt request line.

The block also owns a general-purpose output port. Software never writes the port register directly. One offset sets the bits where the written byte holds a 1, and another offset clears them. An output configuration register decides, for each output, whether the pin follows that port register (manual control) or follows the matching interrupt status bit. The general-purpose inputs are active low. They pass through a synchroniser and are returned unchanged. An input-change word reports the current level of the four lowest inputs, plus sticky change flags for those inputs that a read strobe clears.

An auxiliary control register is also held here. Its top bit selects one of two baud-rate sets, and a three-bit field equal to 6 selects timer mode. The serial engines and the timer sit outside this block and consume these two outputs.

Top module: `duart_sys_regs`

## Requirements
- R1: Reading offset 5 returns the interrupt status word. For channel x, bit 4x is that channel's transmit-ready input and bit 4x+1 is its receive-ready input. Bits 4x+2 and 4x+3 read 0.
- R2: After reset the interrupt mask is 0 and `irq_n` is high, whatever the ready inputs are. A write to offset 5 loads the mask from the low 4·channels bits of the write data.
- R3: `irq_n` is registered. It goes low on the clock edge after which (status AND mask) is nonzero, and it returns high on the edge after which that AND is zero.
- R4: A write to offset 0xE sets each output port bit whose write-data bit is 1. All other bits keep their value.
- R5: A write to offset 0xF clears each output port bit whose write-data bit is 1. All other bits keep their value.
- R6: The output port register and the output configuration register both reset to 0. Where configuration bit k is 0, `out_pins[k]` is the inverse of port bit k, so all pins are high after reset.
- R7: A write to offset 0xD loads the output configuration register. Where configuration bit k is 1 (and k is below 4·channels), `out_pins[k]` is the inverse of interrupt status bit k.
- R8: Reading offset 0xD returns the raw levels of `in_pins` after a two-flop synchroniser (which resets to all ones), with no inversion. Bits above the input width read 0.
- R9: Reading offset 4 returns the synchronised levels of inputs 3:0 in bits 3:0 and the change flags in bits 7:4. A flag sets one clock after a level change becomes visible at offset 0xD. A read strobe (`reg_rd`) at offset 4 clears the flags, and a change in the same cycle wins over the clear.
- R10: A write to offset 4 loads the auxiliary control register. `baud_set` equals its bit 7, and `timer_mode` is high exactly when bits 6:4 equal 6.
- R11: Reads of every other offset return 0. Writes to other offsets, and cycles without a write, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears change flags at offset 4) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ch_tx_rdy | input | 2 | Transmit-ready flag per channel |
| ch_rx_rdy | input | 2 | Receive-ready flag per channel |
| in_pins | input | 6 | General-purpose inputs, active low |
| out_pins | output | 8 | General-purpose outputs, active low |
| irq_n | output | 1 | Interrupt request, active low |
| baud_set | output | 1 | Selected baud-rate set |
| timer_mode | output | 1 | Counter/timer block in timer mode |

## Verification
The hardest case to reach is a change flag that sets in the same cycle as the read strobe that should clear it. The change is three register stages away from the pin, while the strobe acts at once. The stimulus moves the inputs and then issues offset-4 reads at every delay from zero to four cycles, so one of them lands on the cycle where the set and the clear meet. A long random phase then mixes ready-flag toggles, mask writes and configuration changes. This checks that the interrupt line and the pins routed to status bits follow the ready flags with the correct latency.

// File: rtl/duart_sys_pkg.sv
package duart_sys_pkg;
  localparam logic [3:0] OFF_CHG   = 4'h4;
  localparam logic [3:0] OFF_STAT  = 4'h5;
  localparam logic [3:0] OFF_PINS  = 4'hD;
  localparam logic [3:0] OFF_SET   = 4'hE;
  localparam logic [3:0] OFF_CLR   = 4'hF;
  localparam int         LANE_W    = 4;
  localparam int         CHG_W     = 4;
  localparam logic [2:0] TMR_CODE  = 3'd6;

  function automatic int lane_index(input int ch, input bit is_rx);
    return LANE_W * ch + (is_rx ? 1 : 0);
  endfunction

  function automatic logic timer_sel(input logic [7:0] aux);
    return aux[6:4] == TMR_CODE;
  endfunction

  function automatic logic pin_level(input logic manual_bit, input logic alt_bit,
                                     input logic use_alt);
    return ~(use_alt ? alt_bit : manual_bit);
  endfunction

  function automatic logic [7:0] set_bits(input logic [7:0] cur, input logic [7:0] m);
    return cur | m;
  endfunction

  function automatic logic [7:0] clr_bits(input logic [7:0] cur, input logic [7:0] m);
    return cur & ~m;
  endfunction
endpackage

// File: rtl/duart_irq_unit.sv
module duart_irq_unit
  import duart_sys_pkg::*;
#(
  parameter int NCH   = 2,
  localparam int ISR_W = LANE_W * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tx_rdy,
  input  logic [NCH-1:0]   rx_rdy,
  input  logic             mask_we,
  input  logic [ISR_W-1:0] mask_wdata,
  output logic [ISR_W-1:0] isr,
  output logic [ISR_W-1:0] imr_q,
  output logic             pend,
  output logic             irq_n
);
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    localparam int TXI = LANE_W * c;
    assign isr[TXI]            = tx_rdy[c];
    assign isr[TXI+1]          = rx_rdy[c];
    assign isr[TXI+LANE_W-1:TXI+2] = '0;
  end

  assign pend = |(isr & imr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q <= '0;
      irq_n <= 1'b1;
    end else begin
      if (mask_we) imr_q <= mask_wdata;
      irq_n <= ~pend;
    end
  end
endmodule

// File: rtl/duart_gpo_unit.sv
module duart_gpo_unit
  import duart_sys_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             cfg_we,
  input  logic [OUT_W-1:0] wdata,
  input  logic [ISR_W-1:0] isr,
  output logic [OUT_W-1:0] opr_q,
  output logic [OUT_W-1:0] opcr_q,
  output logic [OUT_W-1:0] pins
);
  logic [7:0] wide_cur, wide_msk;
  assign wide_cur = 8'(opr_q);
  assign wide_msk = 8'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opr_q  <= '0;
      opcr_q <= '0;
    end else begin
      if (set_we)      opr_q <= OUT_W'(set_bits(wide_cur, wide_msk));
      else if (clr_we) opr_q <= OUT_W'(clr_bits(wide_cur, wide_msk));
      if (cfg_we) opcr_q <= wdata;
    end
  end

  for (genvar k = 0; k < OUT_W; k++) begin : g_pin
    if (k < ISR_W) begin : g_alt
      assign pins[k] = pin_level(opr_q[k], isr[k], opcr_q[k]);
    end else begin : g_man
      assign pins[k] = pin_level(opr_q[k], 1'b0, 1'b0);
    end
  end
endmodule

// File: rtl/duart_gpi_unit.sv
module duart_gpi_unit
  import duart_sys_pkg::*;
#(
  parameter int IN_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  pins,
  input  logic             chg_clr,
  output logic [IN_W-1:0]  lvl,
  output logic [CHG_W-1:0] chg_flags,
  output logic             chg_evt
);
  logic [IN_W-1:0]  stg [SYNC_STAGES];
  logic [CHG_W-1:0] prev_q;
  logic [CHG_W-1:0] chg_now;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= pins;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign lvl     = stg[SYNC_STAGES-1];
  assign chg_now = lvl[CHG_W-1:0] ^ prev_q;
  assign chg_evt = |chg_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '1;
      chg_flags <= '0;
    end else begin
      prev_q    <= lvl[CHG_W-1:0];
      chg_flags <= (chg_clr ? '0 : chg_flags) | chg_now;
    end
  end
endmodule

// File: rtl/duart_sys_regs.sv
module duart_sys_regs
  import duart_sys_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int IN_W   = 6,
  parameter int OUT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    ch_tx_rdy,
  input  logic [NCH-1:0]    ch_rx_rdy,
  input  logic [IN_W-1:0]   in_pins,
  output logic [OUT_W-1:0]  out_pins,
  output logic              irq_n,
  output logic              baud_set,
  output logic              timer_mode
);
  localparam int ISR_W = LANE_W * NCH;

  logic hit_chg, hit_stat, hit_pins, hit_set, hit_clr;
  assign hit_chg  = reg_addr == ADDR_W'(OFF_CHG);
  assign hit_stat = reg_addr == ADDR_W'(OFF_STAT);
  assign hit_pins = reg_addr == ADDR_W'(OFF_PINS);
  assign hit_set  = reg_addr == ADDR_W'(OFF_SET);
  assign hit_clr  = reg_addr == ADDR_W'(OFF_CLR);

  logic [ISR_W-1:0] isr, imr_q;
  logic             irq_pend;
  logic [OUT_W-1:0] opr_q, opcr_q;
  logic [IN_W-1:0]  in_lvl;
  logic [CHG_W-1:0] chg_flags;
  logic             chg_evt;
  logic [7:0]       aux_q;

  duart_irq_unit #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_rdy(ch_tx_rdy), .rx_rdy(ch_rx_rdy),
    .mask_we(reg_wr && hit_stat), .mask_wdata(reg_wdata[ISR_W-1:0]),
    .isr(isr), .imr_q(imr_q), .pend(irq_pend), .irq_n(irq_n)
  );

  duart_gpo_unit #(.OUT_W(OUT_W), .ISR_W(ISR_W)) u_gpo (
    .clk(clk), .rst_n(rst_n), .set_we(reg_wr && hit_set),
    .clr_we(reg_wr && hit_clr), .cfg_we(reg_wr && hit_pins),
    .wdata(reg_wdata[OUT_W-1:0]), .isr(isr), .opr_q(opr_q),
    .opcr_q(opcr_q), .pins(out_pins)
  );

  duart_gpi_unit #(.IN_W(IN_W), .SYNC_STAGES(2)) u_gpi (
    .clk(clk), .rst_n(rst_n), .pins(in_pins), .chg_clr(reg_rd && hit_chg),
    .lvl(in_lvl), .chg_flags(chg_flags), .chg_evt(chg_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 aux_q <= '0;
    else if (reg_wr && hit_chg) aux_q <= reg_wdata[7:0];
  end
  assign baud_set   = aux_q[7];
  assign timer_mode = timer_sel(aux_q);

  always_comb begin
    reg_rdata = '0;
    if (hit_chg)       reg_rdata[2*CHG_W-1:0] = {chg_flags, in_lvl[CHG_W-1:0]};
    else if (hit_stat) reg_rdata[ISR_W-1:0]   = isr;
    else if (hit_pins) reg_rdata[IN_W-1:0]    = in_lvl;
  end
endmodule

// File: rtl/duart_sys_regs_chk.sv
module duart_sys_regs_chk
  import duart_sys_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int OUT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_n,
  input logic [OUT_W-1:0]  out_pins,
  input logic              timer_mode,
  input logic [OUT_W-1:0]  opr_q,
  input logic [OUT_W-1:0]  opcr_q,
  input logic [CHG_W-1:0]  chg_flags,
  input logic              chg_evt
);
  localparam int ISR_W = LANE_W * NCH;

  AST_MASK_OFF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_STAT) && reg_wdata[ISR_W-1:0] == '0)
      |=> ##1 irq_n); // R3

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_SET))
      |=> ((opr_q & $past(reg_wdata[OUT_W-1:0])) == $past(reg_wdata[OUT_W-1:0]))); // R4

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_CLR))
      |=> ((opr_q & $past(reg_wdata[OUT_W-1:0])) == '0)); // R5

  AST_PIN_LOW_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (opcr_q == '0 && reg_wr && reg_addr == ADDR_W'(OFF_SET))
      |=> ((out_pins & $past(reg_wdata[OUT_W-1:0])) == '0)); // R6

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == ADDR_W'(OFF_SET) || reg_addr == ADDR_W'(OFF_CLR)))
      |=> $stable(opr_q)); // R11

  AST_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFF_CHG) && !chg_evt) |=> (chg_flags == '0)); // R9

  AST_TIMER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_CHG))
      |=> (timer_mode == ($past(reg_wdata[6:4]) == TMR_CODE))); // R10
endmodule

bind duart_sys_regs duart_sys_regs_chk #(
  .NCH(NCH), .OUT_W(OUT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .irq_n(irq_n),
  .out_pins(out_pins), .timer_mode(timer_mode), .opr_q(opr_q),
  .opcr_q(opcr_q), .chg_flags(chg_flags), .chg_evt(chg_evt)
);

// File: tb/duart_sys_regs_tb.sv
module duart_sys_regs_tb;
  localparam int NCH = 2, IN_W = 6, OUT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] ch_tx_rdy = '0, ch_rx_rdy = '0;
  logic [IN_W-1:0] in_pins = '1;
  logic [OUT_W-1:0] out_pins;
  logic irq_n, baud_set, timer_mode;

  always #4 clk = ~clk;

  duart_sys_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_tx_rdy(ch_tx_rdy), .ch_rx_rdy(ch_rx_rdy), .in_pins(in_pins),
    .out_pins(out_pins), .irq_n(irq_n), .baud_set(baud_set),
    .timer_mode(timer_mode)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_imr = 0, m_opr = 0, m_opcr = 0, m_aux = 0, m_chg = 0;
  int m_s1 = 'h3f, m_s2 = 'h3f, m_prev = 'hf;
  bit m_irq_n = 1;

  function automatic int status_word();
    int w = 0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_tx_rdy[c]) w += 1 << (4 * c);
      if (ch_rx_rdy[c]) w += 1 << (4 * c + 1);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_imr = 0; m_opr = 0; m_opcr = 0; m_aux = 0; m_chg = 0;
      m_s1 = 'h3f; m_s2 = 'h3f; m_prev = 'hf; m_irq_n = 1;
    end else begin
      m_irq_n = (status_word() & m_imr) == 0;
      if (reg_rd && reg_addr == 4'h4) m_chg = 0;
      m_chg = m_chg | ((m_s2 & 'hf) ^ m_prev);
      m_prev = m_s2 & 'hf;
      m_s2 = m_s1;
      m_s1 = int'(in_pins);
      if (reg_wr) begin
        case (reg_addr)
          4'h4: m_aux = reg_wdata;
          4'h5: m_imr = reg_wdata;
          4'hD: m_opcr = reg_wdata;
          4'hE: m_opr = m_opr | reg_wdata;
          4'hF: m_opr = m_opr & ~int'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_pins();
    int p = 0;
    int st = status_word();
    for (int k = 0; k < OUT_W; k++) begin
      bit src = m_opcr[k] ? st[k] : m_opr[k];
      if (!src) p += 1 << k;
    end
    return p;
  endfunction

  always @(negedge clk) begin
    int exp_rd;
    string rtag;
    case (reg_addr)
      4'h4: begin exp_rd = (m_chg << 4) | (m_s2 & 'hf); rtag = "R9"; end
      4'h5: begin exp_rd = status_word(); rtag = "R1"; end
      4'hD: begin exp_rd = m_s2; rtag = "R8"; end
      default: begin exp_rd = 0; rtag = "R11"; end
    endcase
    chk(rtag, 32'(reg_rdata), 32'(exp_rd));
    chk(m_opcr == 0 ? "R6" : "R7", 32'(out_pins), 32'(exp_pins()));
    chk(m_imr == 0 ? "R2" : "R3", 32'(irq_n), 32'(m_irq_n));
    chk("R10 baud", 32'(baud_set), 32'(m_aux[7]));
    chk("R10 timer", 32'(timer_mode), 32'(((m_aux >> 4) & 7) == 6));
  end

  task automatic step(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    #1;
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'h0, 1'b0, 1'b0, 8'h00);
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 / R6: reset state
    chk("R2 reset irq", 32'(irq_n), 32'd1);
    chk("R6 reset pins", 32'(out_pins), 32'hff);
    // R11: unmapped offsets read zero, writes ignored
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 5 && a != 13 && a != 14 && a != 15) step(4'(a), 1'b1, 1'b0, 8'hff);
    end
    idle(1);
    #1 chk("R11 pins untouched", 32'(out_pins), 32'hff);
    // R1 / R2: ready flags with mask zero
    ch_tx_rdy = 2'b01; ch_rx_rdy = 2'b10;
    step(4'h5, 1'b0, 1'b0, 8'h00);
    idle(2);
    chk("R2 masked irq", 32'(irq_n), 32'd1);
    step(4'h5, 1'b0, 1'b0, 8'h00);
    #1 chk("R1 status", 32'(reg_rdata), 32'h21);
    // R3: mask selects interrupts
    step(4'h5, 1'b1, 1'b0, 8'h02);
    idle(2);
    chk("R3 no overlap", 32'(irq_n), 32'd1);
    step(4'h5, 1'b1, 1'b0, 8'h20);
    idle(2);
    chk("R3 overlap asserts", 32'(irq_n), 32'd0);
    ch_rx_rdy = 2'b00;
    idle(2);
    chk("R3 deasserts", 32'(irq_n), 32'd1);
    step(4'h5, 1'b1, 1'b0, 8'h11);
    ch_tx_rdy = 2'b10;
    idle(3);
    // R4 / R5: set and clear addresses
    step(4'hE, 1'b1, 1'b0, 8'hA5);
    idle(1);
    #1 chk("R4 set", 32'(out_pins), 32'h5a);
    step(4'hF, 1'b1, 1'b0, 8'h21);
    idle(1);
    #1 chk("R5 clear", 32'(out_pins), 32'h7b);
    step(4'hE, 1'b1, 1'b0, 8'h0F);
    step(4'hF, 1'b1, 1'b0, 8'hF0);
    idle(1);
    #1 chk("R5 clear high", 32'(out_pins), 32'hf0);
    // R7: pins routed to status bits
    step(4'hD, 1'b1, 1'b0, 8'h33);
    ch_tx_rdy = 2'b11; ch_rx_rdy = 2'b01;
    idle(2);
    ch_tx_rdy = 2'b00;
    idle(2);
    step(4'hD, 1'b1, 1'b0, 8'h00);
    idle(2);
    // R8 / R9: input levels and change flags, clear at every delay
    for (int dly = 0; dly < 5; dly++) begin
      in_pins = 6'(6'h15 ^ (dly << 1));
      idle(dly);
      step(4'h4, 1'b0, 1'b1, 8'h00);
      step(4'hD, 1'b0, 1'b0, 8'h00);
      idle(4);
      step(4'h4, 1'b0, 1'b0, 8'h00);
      step(4'h4, 1'b0, 1'b1, 8'h00);
      idle(1);
    end
    // R10: auxiliary control
    step(4'h4, 1'b1, 1'b0, 8'hE0);
    step(4'h4, 1'b1, 1'b0, 8'h60);
    idle(1);
    #1 chk("R10 timer mode", 32'(timer_mode), 32'd1);
    step(4'h4, 1'b1, 1'b0, 8'h70);
    step(4'h4, 1'b1, 1'b0, 8'h80);
    idle(2);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 4'h0) ch_tx_rdy = r[5:4];
      if (r[7:6] == 2'b00) ch_rx_rdy = r[9:8];
      if (r[12:10] == 3'b000) in_pins = r[18:13];
      step(r[22:19], r[23] & r[24], r[25], r[31:24]);
    end
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule